// File: doc/BRIEF.md
# Fixed-Length Memory Bus Cycle Sequencer

This block sits between a processor-side request port and an asynchronous memory that has no clock of its own. Each accepted request, read or write, is stretched into a bus cycle of a fixed number of clocks. The number is set at elaboration from the clock period and the memory's slower timing figure, rounded up. The address and the memory enable go out in the first clock of the cycle. The read/write select and the write data follow one clock later, so the address has settled before the strobe. All of them are held unchanged until the last clock of the cycle ends.

For a read, the word on the memory's data lines is captured at the end of the last clock. It is then presented on the response port together with a one-clock completion pulse. While a cycle is running, the request port shows not-ready and refuses new work. A request that is waiting when the completion pulse is high is taken at the next edge, so bus cycles can run back to back. Between cycles the memory is disabled, the select rests at read, and the write-data drivers are off.

Top module: `mem_bus_seq`

## Requirements
- R1: While reset is held: memEn=0, memRw=1 (1 means read), memWdataOe=0, reqReady=1, rspDone=0 and rspRdata=0.
- R2: Every bus cycle keeps memEn high for exactly SLOTS consecutive clocks. SLOTS = max(2, ceil(max(ACCESS_PS, WRITE_PS) / CLK_PERIOD_PS)), which gives 4 with the defaults (20 ns clock, 65 ns access, 75 ns write).
- R3: In the first clock of a cycle, memEn=1 and memAddr shows the accepted address, while memRw stays 1 and memWdataOe stays 0.
- R4: For a write, from the second clock to the last clock of the cycle, memRw=0, memWdataOe=1 and memWdata equals the accepted write data.
- R5: For a read, memRw stays 1 and memWdataOe stays 0 through the whole cycle. rspRdata takes the value of memRdata sampled at the end of the last clock.
- R6: memAddr and memWdata keep the values accepted with the request for the whole cycle, even when reqAddr and reqWdata change after acceptance.
- R7: rspDone is high for exactly one clock, the clock after the last bus clock. A write cycle leaves rspRdata unchanged.
- R8: reqReady is 0 from the accepting edge until the completion clock. A request presented while reqReady is 0 is not taken.
- R9: A request presented during the completion clock is accepted at the following edge, and its first bus clock follows at once.
- R10: With no request pending, memEn=0, memRw=1 and memWdataOe=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Write data |
| rspRdata | output | DATA_W | Last word read |
| rspDone | output | 1 | One-clock completion pulse |
| memAddr | output | ADDR_W | Memory address |
| memEn | output | 1 | Memory enable |
| memRw | output | 1 | Memory select, 1 = read, 0 = write |
| memWdata | output | DATA_W | Write data toward memory |
| memWdataOe | output | 1 | Write-data drive enable |
| memRdata | input | DATA_W | Data returned by memory |

## Verification
The bench targets three timing faults. A strobe issued in the first clock would make memRw fall together with the enable. A cycle one clock short or one clock long would move the completion pulse and the capture. Bus values that follow the request port instead of the latched copy would change memAddr in the middle of a cycle once the bench scrambles reqAddr. The bench also keeps reqValid high across a busy cycle. A sequencer that ignored reqReady would start a second cycle early, and one that wasted a clock after completion would show memEn low in the clock where the bench expects the next first clock. Reads after writes to the same address confirm that capture happens on the last clock and that a write does not disturb rspRdata.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef struct packed {
    logic load;      // latch request fields this edge
    logic busEn;     // bus cycle in progress
    logic drvWrite;  // strobe phase of a write
    logic capture;   // sample read data this edge
  } mbsStrobes_t;
endpackage

// File: rtl/mbs_ctrl.sv
module mbs_ctrl
  import mbs_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        reqReady,
  output logic        rspDone,
  output mbsStrobes_t strobes
);
  localparam int CW = $clog2(SLOTS + 1);
  localparam logic [CW-1:0] LAST = CW'(SLOTS);

  logic [CW-1:0] phase;   // 0 idle, 1..SLOTS bus clocks
  logic          isWrite;
  logic          lastSlot;

  assign lastSlot = (phase == LAST);
  assign reqReady = (phase == '0);

  always_comb begin
    strobes          = '0;
    strobes.load     = reqValid && reqReady;
    strobes.busEn    = (phase != '0);
    strobes.drvWrite = isWrite && (phase > CW'(1));
    strobes.capture  = lastSlot && !isWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      isWrite <= 1'b0;
      rspDone <= 1'b0;
    end else begin
      rspDone <= lastSlot;
      if (lastSlot) begin
        phase <= '0;
      end else if (phase != '0) begin
        phase <= phase + 1'b1;
      end else if (reqValid) begin
        phase   <= CW'(1);
        isWrite <= reqWrite;
      end
    end
  end

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);
  assert_refuse_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> !reqReady);
  assert_first_slot_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobes.busEn) |-> !strobes.drvWrite);
  assert_done_after_bus_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> ($past(strobes.busEn) && !strobes.busEn));
endmodule

// File: rtl/mbs_datapath.sv
module mbs_datapath
  import mbs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mbsStrobes_t       strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memEn,
  output logic              memRw,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWdataOe
);
  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rspRdata <= '0;
    end else begin
      if (strobes.load) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (strobes.capture) rspRdata <= memRdata;
    end
  end

  assign memAddr    = addrReg;
  assign memWdata   = wdataReg;
  assign memEn      = strobes.busEn;
  assign memRw      = !strobes.drvWrite;
  assign memWdataOe = strobes.drvWrite;

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && $past(memEn)) |-> $stable(memAddr));
  assert_wdata_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memWdataOe && $past(memWdataOe)) |-> $stable(memWdata));
  assert_strobe_in_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memRw) |-> $past(memEn));
endmodule

// File: rtl/mem_bus_seq.sv
module mem_bus_seq
  import mbs_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_PS = 20000,
  parameter int ACCESS_PS     = 65000,
  parameter int WRITE_PS      = 75000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memEn,
  output logic              memRw,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWdataOe,
  input  logic [DATA_W-1:0] memRdata
);
  localparam int SLOW_PS = (ACCESS_PS > WRITE_PS) ? ACCESS_PS : WRITE_PS;
  localparam int RAW     = (SLOW_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int SLOTS   = (RAW < 2) ? 2 : RAW;

  mbsStrobes_t strobes;

  mbs_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .rspDone(rspDone), .strobes(strobes)
  );

  mbs_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memRdata(memRdata), .rspRdata(rspRdata),
    .memAddr(memAddr), .memEn(memEn), .memRw(memRw),
    .memWdata(memWdata), .memWdataOe(memWdataOe)
  );
endmodule

// File: tb/mem_bus_seq_bench.sv
`timescale 1ns/1ps
module mem_bus_seq_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  // R2: ceil(75 / 20) = 4, above the floor of 2
  localparam int EXP_SLOTS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic reqReady, rspDone, memEn, memRw, memWdataOe;
  logic [DW-1:0] rspRdata, memWdata, memRdata;
  logic [AW-1:0] memAddr;

  logic [DW-1:0] benchMem [16];
  logic [DW-1:0] expMem [16];

  int total = 0, bad = 0, cycles = 0;
  int mPhase = 0;
  bit mWrite = 0, mDone = 0;
  logic [AW-1:0] mAddr = '0;
  logic [DW-1:0] mWdata = '0, mRdata = '0;

  always #10 clk = ~clk;

  assign memRdata = benchMem[memAddr[3:0]];

  mem_bus_seq u_mem_bus_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspRdata(rspRdata), .rspDone(rspDone), .memAddr(memAddr),
    .memEn(memEn), .memRw(memRw), .memWdata(memWdata),
    .memWdataOe(memWdataOe), .memRdata(memRdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // reference model, compared every cycle at the falling edge
  always @(negedge clk) begin
    cycles++;
    if (!rstN) begin
      mPhase = 0; mDone = 0; mRdata = '0; mWrite = 0;
    end else begin
      bit eEn, eRw, eOe;
      eEn = (mPhase != 0);
      eOe = mWrite && (mPhase >= 2);
      eRw = !eOe;
      chk(memEn === eEn, "R2 memEn", memEn, eEn);
      chk(memRw === eRw, "R4 memRw", memRw, eRw);
      chk(memWdataOe === eOe, "R4 memWdataOe", memWdataOe, eOe);
      if (eEn) chk(memAddr === mAddr, "R6 memAddr", memAddr, mAddr);
      if (eOe) chk(memWdata === mWdata, "R6 memWdata", memWdata, mWdata);
      chk(reqReady === (mPhase == 0), "R8 reqReady", reqReady, mPhase == 0);
      chk(rspDone === mDone, "R7 rspDone", rspDone, mDone);
      chk(rspRdata === mRdata, "R5 rspRdata", rspRdata, mRdata);
      if (memEn && !memRw && memWdataOe) benchMem[memAddr[3:0]] = memWdata;
      mDone = (mPhase == EXP_SLOTS);
      if (mPhase == EXP_SLOTS) begin
        if (mWrite) expMem[mAddr[3:0]] = mWdata;
        else mRdata = expMem[mAddr[3:0]];
        mPhase = 0;
      end else if (mPhase != 0) begin
        mPhase++;
      end else if (reqValid) begin
        mPhase = 1; mWrite = reqWrite; mAddr = reqAddr; mWdata = reqWdata;
      end
    end
  end

  always @(posedge clk) begin
    if (cycles > 20000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      finishRun();
    end
  end

  // present a request, hand it over, then scramble the port (R6)
  task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    @(posedge clk); #2;
    reqValid = 1'b0; reqAddr = ~a; reqWdata = ~d; reqWrite = ~w;
    @(negedge clk); #1;
    chk(memEn === 1'b1, "R3 first clock enable", memEn, 1);
    chk(memRw === 1'b1, "R3 first clock select", memRw, 1);
    chk(memWdataOe === 1'b0, "R3 first clock drive", memWdataOe, 0);
    chk(memAddr === a, "R3 first clock address", memAddr, a);
  endtask

  task automatic waitDone();
    @(negedge clk);
    while (!rspDone) @(negedge clk);
    @(posedge clk); #2;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      benchMem[i] = DW'(i * 37 + 5);
      expMem[i]   = DW'(i * 37 + 5);
    end
    repeat (3) @(posedge clk);
    #5;
    chk(memEn === 1'b0, "R1 memEn", memEn, 0);
    chk(memRw === 1'b1, "R1 memRw", memRw, 1);
    chk(memWdataOe === 1'b0, "R1 memWdataOe", memWdataOe, 0);
    chk(reqReady === 1'b1, "R1 reqReady", reqReady, 1);
    chk(rspDone === 1'b0, "R1 rspDone", rspDone, 0);
    chk(rspRdata === '0, "R1 rspRdata", rspRdata, 0);
    @(posedge clk); #2; rstN = 1'b1;

    issue(1'b0, 8'h02, 16'h0);          // R5 read of preset word
    waitDone();
    issue(1'b1, 8'h13, 16'hA5C3);       // R4 write
    waitDone();
    issue(1'b0, 8'h03, 16'h0);          // R5 read back, aliasing low bits
    // R8: a request offered mid-cycle must not start anything
    @(posedge clk); #2;
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 8'h07; reqWdata = 16'hDEAD;
    @(negedge clk); #1;
    chk(reqReady === 1'b0, "R8 busy refuses", reqReady, 0);
    @(posedge clk); #2; reqValid = 1'b0;
    waitDone();
    repeat (3) @(negedge clk);
    #1;
    chk(memEn === 1'b0, "R10 idle enable", memEn, 0);
    chk(memRw === 1'b1, "R10 idle select", memRw, 1);
    chk(memWdataOe === 1'b0, "R10 idle drive", memWdataOe, 0);

    // R9: request waiting through the done clock starts at once
    @(posedge clk); #2;
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 8'h05; reqWdata = 16'h1234;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    @(posedge clk); #2;
    reqWrite = 1'b0; reqAddr = 8'h05;   // second request, held valid
    @(negedge clk);
    while (!rspDone) @(negedge clk);
    #1;
    chk(reqReady === 1'b1, "R9 ready in done clock", reqReady, 1);
    @(negedge clk); #1;
    chk(memEn === 1'b1, "R9 next cycle starts at once", memEn, 1);
    @(posedge clk); #2; reqValid = 1'b0;
    waitDone();
    #1;
    chk(rspRdata === 16'h1234, "R5 read after write", rspRdata, 16'h1234);
    issue(1'b1, 8'h09, 16'h0F0F);       // R7 write keeps rspRdata
    waitDone();
    repeat (4) @(negedge clk);
    finishRun();
  end
endmodule